// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read path of a byte-wide nonvolatile memory. It chooses what the data bus returns on a read. When no internal programming cycle is running, a read returns the array contents at the addressed location. While a programming cycle is busy, the block reports progress on two bits instead. A write that protection blocks also counts as busy, because it runs the same timed cycle.

The two progress bits work independently. The top bit gives the inverse of the top bit of the byte last written, but only when the read addresses the location last written. Bit 6 flips once for each new read access. A host can therefore tell that programming has finished in either of two ways: the top bit reads back true, or bit 6 stops changing. The other bits always carry array data.

The strobes are active low and are sampled on the block clock. A read access is the condition chip enable low, output enable low and write enable high. A new access starts on the first cycle in which that condition holds after a cycle in which it did not. Raising output enable, chip enable or both for at least one cycle therefore ends an access. The bus output and its enable are registered, so they follow the sampled inputs by one clock.

Top module: `wr_status_reporter`

## Requirements
- R1: `rd_oe` is 1 in the cycle after an edge that samples `ce_n`=0, `oe_n`=0, `we_n`=1, and 0 after any other sampled combination.
- R2: When `rd_oe` is 0, `rd_data` is all zeros.
- R3: After an edge that samples `busy`=0 with a read access, `rd_data` equals the sampled `arr_data` on every bit, and bit 6 does not alternate between accesses.
- R4: After an edge that samples `busy`=1, a read access and `rd_addr` equal to `wr_last_addr`, bit 7 of `rd_data` is the inverse of the sampled `wr_last_msb`.
- R5: After an edge that samples `busy`=1, a read access and `rd_addr` different from `wr_last_addr`, bit 7 of `rd_data` equals bit 7 of the sampled `arr_data`.
- R6: After an edge that samples `busy`=1 and a read access, bits 5 to 0 of `rd_data` equal the same bits of the sampled `arr_data`.
- R7: While busy, bit 6 of `rd_data` at the start of each new read access is the inverse of its value at the start of the previous busy access.
- R8: While the read condition is held across consecutive busy cycles, bit 6 of `rd_data` stays unchanged.
- R9: A new access is started by raising only `oe_n` for one cycle, or only `ce_n` for one cycle, and then lowering it again.
- R10: Reset clears `rd_oe`, `rd_data` and the toggle state, so the first busy access after reset shows bit 6 = 1.
- R11: Read accesses made while `busy` is 0 do not advance the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | ADDR_W | Address of the current read |
| arr_data | input | DATA_W | Array contents at `rd_addr` |
| busy | input | 1 | Internal programming cycle in progress |
| wr_last_addr | input | ADDR_W | Address of the byte most recently written |
| wr_last_msb | input | 1 | Bit 7 of the byte most recently written |
| rd_data | output | DATA_W | Registered read bus value |
| rd_oe | output | 1 | Registered bus drive enable |

## Verification
The properties assume that every input is synchronous to `clk` and is sampled once per rising edge. They also assume that `arr_data` always reflects the location at `rd_addr` in the same cycle, and that `wr_last_addr` and `wr_last_msb` come from write logic that holds them constant while `busy` is high. The stimulus changes inputs only on falling edges. It sets the address, array word and last-write values before it lowers a strobe, and it leaves them unchanged through a held access. Because of this, every registered output can be predicted from the values sampled at the preceding rising edge.

// File: rtl/wcsr_pkg.sv
package wcsr_pkg;

    // Bit positions of the two progress indicators on the read bus
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    // Source selected for the next bus value
    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    // Decoded read strobe: level and first-cycle marker
    typedef struct packed {
        logic en;
        logic start;
    } strobe_t;

    function automatic logic read_cond(input logic ce_n, input logic oe_n, input logic we_n);
        return ~ce_n & ~oe_n & we_n;
    endfunction

endpackage

// File: rtl/wcsr_strobe.sv
module wcsr_strobe
    import wcsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output strobe_t strb
);

    logic en_now;
    logic en_q;

    assign en_now = read_cond(ce_n, oe_n, we_n);

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_now;
    end

    // An access begins on the first cycle of an active strobe
    assign strb.en    = en_now;
    assign strb.start = en_now & ~en_q;

endmodule

// File: rtl/wcsr_toggle.sv
module wcsr_toggle
    import wcsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  strobe_t strb,
    output logic    tgl_next
);

    logic tgl_q;

    // Advance only on a fresh access during a programming cycle
    assign tgl_next = (busy & strb.start) ? ~tgl_q : tgl_q;

    always_ff @(posedge clk) begin
        if (rst) tgl_q <= 1'b0;
        else     tgl_q <= tgl_next;
    end

endmodule

// File: rtl/wcsr_mux.sv
module wcsr_mux
    import wcsr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  strobe_t           strb,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [ADDR_W-1:0] wr_last_addr,
    input  logic              wr_last_msb,
    input  logic              tgl,
    output rd_src_e           src,
    output logic [DATA_W-1:0] data_next
);

    logic              addr_hit;
    logic [DATA_W-1:0] status_word;

    assign addr_hit = (rd_addr == wr_last_addr);

    // Per-bit composition of the busy-time status word
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign status_word[i] = addr_hit ? ~wr_last_msb : arr_data[i];
        end else if (i == TOGGLE_BIT) begin : g_tgl
            assign status_word[i] = tgl;
        end else begin : g_pass
            assign status_word[i] = arr_data[i];
        end
    end

    always_comb begin
        if (!strb.en)  src = SRC_IDLE;
        else if (busy) src = SRC_STATUS;
        else           src = SRC_ARRAY;
    end

    always_comb begin
        unique case (src)
            SRC_ARRAY:  data_next = arr_data;
            SRC_STATUS: data_next = status_word;
            default:    data_next = '0;
        endcase
    end

endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter
    import wcsr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_last_addr,
    input  logic              wr_last_msb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    strobe_t           strb;
    logic              tgl_next;
    rd_src_e           src;
    logic [DATA_W-1:0] data_next;

    wcsr_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .strb (strb)
    );

    wcsr_toggle u_toggle (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .strb     (strb),
        .tgl_next (tgl_next)
    );

    wcsr_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .strb         (strb),
        .busy         (busy),
        .rd_addr      (rd_addr),
        .arr_data     (arr_data),
        .wr_last_addr (wr_last_addr),
        .wr_last_msb  (wr_last_msb),
        .tgl          (tgl_next),
        .src          (src),
        .data_next    (data_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_oe   <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_oe   <= (src != SRC_IDLE);
            rd_data <= data_next;
        end
    end

endmodule

// File: rtl/wr_status_reporter_chk.sv
module wr_status_reporter_chk
    import wcsr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] arr_data,
    input logic              busy,
    input logic [ADDR_W-1:0] wr_last_addr,
    input logic              wr_last_msb,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe
);

    localparam logic [DATA_W-1:0] STAT_MASK =
        (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

    logic pv1;
    logic pv2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv1 <= 1'b0;
            pv2 <= 1'b0;
        end else begin
            pv1 <= 1'b1;
            pv2 <= pv1;
        end
    end

    // R1
    oe_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pv1 |-> (rd_oe == $past(~ce_n & ~oe_n & we_n)));

    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> (rd_data == '0));

    // R3
    ready_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (pv1 && rd_oe && !$past(busy)) |-> (rd_data == $past(arr_data)));

    // R4
    poll_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (pv1 && rd_oe && $past(busy) && $past(rd_addr == wr_last_addr))
        |-> (rd_data[POLL_BIT] == ~$past(wr_last_msb)));

    // R5
    poll_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (pv1 && rd_oe && $past(busy) && $past(rd_addr != wr_last_addr))
        |-> (rd_data[POLL_BIT] == $past(arr_data[POLL_BIT])));

    // R6
    busy_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (pv1 && rd_oe && $past(busy))
        |-> ((rd_data & ~STAT_MASK) == ($past(arr_data) & ~STAT_MASK)));

    // R8
    hold_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (pv2 && rd_oe && $past(rd_oe) && $past(busy) && $past(busy, 2))
        |-> (rd_data[TOGGLE_BIT] == $past(rd_data[TOGGLE_BIT])));

endmodule

bind wr_status_reporter wr_status_reporter_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .rd_addr      (rd_addr),
    .arr_data     (arr_data),
    .busy         (busy),
    .wr_last_addr (wr_last_addr),
    .wr_last_msb  (wr_last_msb),
    .rd_data      (rd_data),
    .rd_oe        (rd_oe)
);

// File: tb/sim_wr_status_reporter.sv
module sim_wr_status_reporter;

    localparam int AW = 17;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] wr_last_addr = '0;
    logic          wr_last_msb = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wr_status_reporter #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .rd_addr      (rd_addr),
        .arr_data     (arr_data),
        .busy         (busy),
        .wr_last_addr (wr_last_addr),
        .wr_last_msb  (wr_last_msb),
        .rd_data      (rd_data),
        .rd_oe        (rd_oe)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge: apply strobes, return at the next falling edge
    task automatic step(input logic c, input logic o, input logic w);
        ce_n = c;
        oe_n = o;
        we_n = w;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10 rd_oe in reset", {7'd0, rd_oe}, 8'h00);
        chk("R10 rd_data in reset", rd_data, 8'h00);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle_reads();
        busy = 1'b0;
        rd_addr = 17'h00100;
        arr_data = 8'hA5;
        step(1'b0, 1'b0, 1'b1);
        chk("R1 rd_oe on read", {7'd0, rd_oe}, 8'h01);
        chk("R3 array data when ready", rd_data, 8'hA5);
        step(1'b0, 1'b0, 1'b0);
        chk("R1 rd_oe with write low", {7'd0, rd_oe}, 8'h00);
        chk("R2 bus zero with write low", rd_data, 8'h00);
        step(1'b1, 1'b0, 1'b1);
        chk("R2 bus zero when deselected", rd_data, 8'h00);
        step(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_poll_hit_hold();
        busy = 1'b1;
        wr_last_addr = 17'h01234;
        wr_last_msb = 1'b1;
        rd_addr = 17'h01234;
        arr_data = 8'h3C;
        step(1'b0, 1'b0, 1'b1);
        // toggle 0 -> 1 on first busy access, bit 7 inverted
        chk("R4 R10 R6 first busy poll", rd_data, 8'h7C);
        arr_data = 8'h3D;
        step(1'b0, 1'b0, 1'b1);
        chk("R8 R6 held strobe keeps bit 6", rd_data, 8'h7D);
    endtask

    task automatic t_toggle_edges();
        step(1'b0, 1'b1, 1'b1);
        chk("R9 rd_oe low during oe pulse", {7'd0, rd_oe}, 8'h00);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 R9 oe-only pulse flips bit 6", rd_data, 8'h3D);
        step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 R9 ce-only pulse flips bit 6", rd_data, 8'h7D);
    endtask

    task automatic t_poll_miss();
        rd_addr = 17'h00042;
        arr_data = 8'hD5;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        // toggle 1 -> 0; bit 7 from array; bit 6 from toggle
        chk("R5 R7 other address", rd_data, 8'h95);
    endtask

    task automatic t_resume_after_idle();
        busy = 1'b0;
        arr_data = 8'h40;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R3 ready read mid-sequence", rd_data, 8'h40);
        busy = 1'b1;
        rd_addr = 17'h01234;
        wr_last_msb = 1'b0;
        arr_data = 8'h00;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        // toggle 0 -> 1 only if the ready read did not advance it
        chk("R11 R4 toggle unaffected by ready read", rd_data, 8'hC0);
    endtask

    task automatic t_write_done();
        busy = 1'b0;
        arr_data = 8'h12;
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R3 true data after completion", rd_data, 8'h12);
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R3 bit 6 steady after completion", rd_data, 8'h12);
        step(1'b1, 1'b1, 1'b1);
        chk("R1 rd_oe low after deselect", {7'd0, rd_oe}, 8'h00);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_reads();
        t_poll_hit_hold();
        t_toggle_edges();
        t_poll_miss();
        t_resume_after_idle();
        t_write_done();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule